// File: doc/BRIEF.md
# Keyed Slow-Clock Source Selector

This block produces the slow timekeeping beat for an always-on domain. It can take the beat from either of two sources. The first is an internal RC oscillator path, which is divided down. The second is an external crystal input, which is passed through untouched. Each source is presented to the block as a one-cycle enable pulse in the system clock domain. The output is also a one-cycle enable (`slow_tick`), not a derived clock. A second output (`slow_out_tick`) carries a gated copy of the same beat for the pin side.

Software programs the block through a small register port:
- **Control word (address 0).** A write is accepted only when the upper half carries an unlock key. The word holds the source select, a separate enable for the external source, and a bypass for the automatic fallback.
- **Divider word (address 1).** Sets the programmable divide factor of the internal path.
- **Gate word (address 2).** Switches the pin-side copy on or off.

When the external source is selected and its presence signal drops, the hardware returns to the internal path by itself, unless the bypass is set.

Top module: `lsc_top`

## Requirements
- R1: After reset, the control, divider and gate words all read as zero, the internal path is selected, and neither output pulses.
- R2: A write to address 0 updates the control bits only when wdata[31:16] equals 16'h16AA. With any other upper value, every control bit keeps its previous value.
- R3: Reading address 0 returns zero in bits 31:16, the fallback bypass in bit 15, the external enable in bit 4, the source select in bit 0 (1 = external), and zero in all other bits.
- R4: With the internal path selected, slow_tick pulses once every FIX_DIV*(N+1) internal input pulses, where N is bits [4:0] of address 1. Each pulse appears one cycle after the internal input pulse that completes the count.
- R5: A new N written to address 1 does not change the interval in progress. It applies from the next counter reload.
- R6: With bits 0 and 4 of the control word both set, each ext_osc_tick pulse produces a slow_tick one cycle later, and internal input pulses produce none.
- R7: With bit 0 set and bit 4 clear, slow_tick stays low whatever the two inputs do.
- R8: With bit 0 set, bit 15 clear and ext_osc_ok low, the hardware clears bit 0 on the next edge, and the internal path resumes.
- R9: With bit 15 set, bit 0 holds at 1 even while ext_osc_ok is low.
- R10: Bit 0 of address 2 gates slow_out_tick. When it is 1, slow_out_tick copies slow_tick in the same cycle. When it is 0, slow_out_tick stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 divider, 2 gate |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| int_osc_tick | input | 1 | Enable pulse from the internal RC oscillator |
| ext_osc_tick | input | 1 | Enable pulse from the external crystal |
| ext_osc_ok | input | 1 | External oscillator present |
| slow_tick | output | 1 | Selected slow beat, one cycle wide |
| slow_out_tick | output | 1 | Gated copy of slow_tick for the pin side |

## Verification
The bench goes after the cases where a plausible mistake changes the beat without breaking anything obvious.

- **Wrong key.** A write with a wrong key must leave the control word untouched. A design that ignores the key would switch source on any write.
- **Divider change mid-interval.** When N changes part-way through an interval, the old interval must finish first. A design that compares against N live would shorten or stretch the interval in flight.
- **Period and latency.** The interval is measured in cycles, so an off-by-one in the (N+1) divide or in the fixed prescaler shows up directly.
- **External source.** Internal pulses must be ignored while the external source is selected. When the external enable is clear, no beat may appear at all.
- **Fallback and bypass.** Dropping the external presence signal must clear the select bit unless the bypass is set.
- **Gate.** The gate must keep the pin copy silent when off, and follow the beat exactly when on.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

    localparam logic [15:0] UNLOCK_KEY = 16'h16AA;

    typedef enum logic [1:0] {
        A_CTRL  = 2'd0,
        A_DIV   = 2'd1,
        A_GATE  = 2'd2,
        A_SPARE = 2'd3
    } addr_e;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

    typedef struct packed {
        logic bypass;   // word bit 15
        logic ext_en;   // word bit 4
        src_e sel;      // word bit 0
    } ctrl_t;

    function automatic logic key_ok(input logic [31:0] w);
        return w[31:16] == UNLOCK_KEY;
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [31:0] w);
        ctrl_t c;
        c.bypass = w[15];
        c.ext_en = w[4];
        c.sel    = src_e'(w[0]);
        return c;
    endfunction

    function automatic logic [31:0] pack_ctrl(input ctrl_t c);
        logic [31:0] w;
        w     = '0;
        w[15] = c.bypass;
        w[4]  = c.ext_en;
        w[0]  = c.sel;
        return w;
    endfunction

endpackage

// File: rtl/lsc_regs.sv
module lsc_regs
    import lsc_pkg::*;
#(
    parameter int NDIV_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [31:0]       wdata,
    input  logic              ext_ok,
    output ctrl_t             ctrl,
    output logic [NDIV_W-1:0] ndiv,
    output logic              gate_en,
    output logic [31:0]       rdata
);
    localparam int DIV_PAD = 32 - NDIV_W;

    addr_e a;
    logic  ctrl_wr;
    logic  lost_ext;
    logic  wdata_unused;

    assign a            = addr_e'(addr);
    assign ctrl_wr      = we && (a == A_CTRL) && key_ok(wdata);
    assign lost_ext     = (ctrl.sel == SRC_EXT) && !ctrl.bypass && !ext_ok;
    assign wdata_unused = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= unpack_ctrl(wdata);
        end else if (lost_ext) begin
            ctrl.sel <= SRC_INT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ndiv    <= '0;
            gate_en <= 1'b0;
        end else if (we) begin
            if (a == A_DIV)  ndiv    <= wdata[NDIV_W-1:0];
            if (a == A_GATE) gate_en <= wdata[0];
        end
    end

    always_comb begin
        unique case (a)
            A_CTRL:  rdata = pack_ctrl(ctrl);
            A_DIV:   rdata = {{DIV_PAD{1'b0}}, ndiv};
            A_GATE:  rdata = {31'd0, gate_en};
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/lsc_divider.sv
module lsc_divider #(
    parameter int FIX_DIV = 32,
    parameter int NDIV_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_tick,
    input  logic [NDIV_W-1:0] ndiv,
    output logic              div_tick
);
    logic              pre_fire;
    logic [NDIV_W-1:0] dcnt;

    generate
        if (FIX_DIV > 1) begin : g_pre
            localparam int PW = $clog2(FIX_DIV);
            localparam logic [PW-1:0] PRE_LAST = PW'(FIX_DIV - 1);
            logic [PW-1:0] pre_cnt;

            always_ff @(posedge clk) begin
                if (rst)          pre_cnt <= '0;
                else if (in_tick) pre_cnt <= (pre_cnt == PRE_LAST) ? '0 : pre_cnt + 1'b1;
            end

            assign pre_fire = in_tick && (pre_cnt == PRE_LAST);
        end else begin : g_nopre
            assign pre_fire = in_tick;
        end
    endgenerate

    // Down-counter: reloads with the divide value only when it fires.
    always_ff @(posedge clk) begin
        if (rst)           dcnt <= '0;
        else if (pre_fire) dcnt <= (dcnt == '0) ? ndiv : dcnt - 1'b1;
    end

    assign div_tick = pre_fire && (dcnt == '0);

endmodule

// File: rtl/lsc_mux.sv
module lsc_mux
    import lsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  int_tick,
    input  logic  ext_tick,
    input  logic  gate_en,
    output logic  slow_tick,
    output logic  out_tick
);
    logic pick;

    always_comb begin
        unique case (ctrl.sel)
            SRC_EXT: pick = ctrl.ext_en && ext_tick;
            default: pick = int_tick;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slow_tick <= 1'b0;
            out_tick  <= 1'b0;
        end else begin
            slow_tick <= pick;
            out_tick  <= pick && gate_en;
        end
    end

endmodule

// File: rtl/lsc_top.sv
module lsc_top
    import lsc_pkg::*;
#(
    parameter int FIX_DIV = 32,
    parameter int NDIV_W  = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        int_osc_tick,
    input  logic        ext_osc_tick,
    input  logic        ext_osc_ok,
    output logic        slow_tick,
    output logic        slow_out_tick
);
    ctrl_t             ctrl_q;
    logic [NDIV_W-1:0] ndiv_q;
    logic              gate_q;
    logic              int_div_tick;

    lsc_regs #(.NDIV_W(NDIV_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .ext_ok  (ext_osc_ok),
        .ctrl    (ctrl_q),
        .ndiv    (ndiv_q),
        .gate_en (gate_q),
        .rdata   (reg_rdata)
    );

    lsc_divider #(.FIX_DIV(FIX_DIV), .NDIV_W(NDIV_W)) u_div (
        .clk      (clk),
        .rst      (rst),
        .in_tick  (int_osc_tick),
        .ndiv     (ndiv_q),
        .div_tick (int_div_tick)
    );

    lsc_mux u_mux (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl_q),
        .int_tick  (int_div_tick),
        .ext_tick  (ext_osc_tick),
        .gate_en   (gate_q),
        .slow_tick (slow_tick),
        .out_tick  (slow_out_tick)
    );

endmodule

// File: rtl/lsc_chk.sv
module lsc_chk
    import lsc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        ext_osc_tick,
    input logic        ext_osc_ok,
    input logic        slow_tick,
    input logic        slow_out_tick,
    input ctrl_t       ctrl
);
    logic ctrl_wr;
    logic bad_key_wr;

    assign ctrl_wr    = reg_we && (reg_addr == 2'd0) && (reg_wdata[31:16] == UNLOCK_KEY);
    assign bad_key_wr = reg_we && (reg_addr == 2'd0) && (reg_wdata[31:16] != UNLOCK_KEY);

    a_r2_bad_key_holds: assert property (@(posedge clk) disable iff (rst)
        bad_key_wr |=> ($stable(ctrl.bypass) && $stable(ctrl.ext_en)));

    a_r3_key_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> (reg_rdata[31:16] == 16'h0));

    a_r6_ext_follows: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel == SRC_EXT && ctrl.ext_en && !ctrl_wr) |=> (slow_tick == $past(ext_osc_tick)));

    a_r7_no_enable_silent: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel == SRC_EXT && !ctrl.ext_en) |=> !slow_tick);

    a_r8_fallback: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel == SRC_EXT && !ctrl.bypass && !ext_osc_ok && !ctrl_wr) |=> (ctrl.sel == SRC_INT));

    a_r9_bypass_holds: assert property (@(posedge clk) disable iff (rst)
        (ctrl.sel == SRC_EXT && ctrl.bypass && !ctrl_wr) |=> (ctrl.sel == SRC_EXT));

    a_r10_copy_only_beat: assert property (@(posedge clk) disable iff (rst)
        slow_out_tick |-> slow_tick);

endmodule

bind lsc_top lsc_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_we        (reg_we),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .ext_osc_tick  (ext_osc_tick),
    .ext_osc_ok    (ext_osc_ok),
    .slow_tick     (slow_tick),
    .slow_out_tick (slow_out_tick),
    .ctrl          (ctrl_q)
);

// File: tb/sim_lsc_top.sv
module sim_lsc_top;
    localparam int FIX = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        int_osc_tick = 1'b0;
    logic        ext_osc_tick = 1'b0;
    logic        ext_osc_ok = 1'b0;
    logic        slow_tick;
    logic        slow_out_tick;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_cyc = 0;
    int last_gap = 0;
    int tick_cnt = 0;
    int out_cnt = 0;

    always #10 clk = ~clk;

    lsc_top u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_osc_tick(int_osc_tick), .ext_osc_tick(ext_osc_tick),
        .ext_osc_ok(ext_osc_ok), .slow_tick(slow_tick),
        .slow_out_tick(slow_out_tick)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (slow_tick) begin
            last_gap = cyc - last_cyc;
            last_cyc = cyc;
            tick_cnt = tick_cnt + 1;
        end
        if (slow_out_tick) out_cnt = out_cnt + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic wait_ticks(input int k);
        int start = tick_cnt;
        int guard = 0;
        while (tick_cnt < start + k && guard < 6000) begin
            @(negedge clk);
            guard++;
        end
        if (guard >= 6000) chk("wait_ticks", 32'(tick_cnt - start), 32'(k));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); chk("R1 ctrl", d, 32'h0);
        rd(2'd1, d); chk("R1 div", d, 32'h0);
        rd(2'd2, d); chk("R1 gate", d, 32'h0);
        chk("R1 no beat", 32'(tick_cnt + out_cnt), 32'h0);
    endtask

    task automatic t_period;
        int_osc_tick = 1'b1;
        wr(2'd1, 32'd0);  wait_ticks(3); chk("R4 N=0 gap", 32'(last_gap), 32'(FIX));
        wr(2'd1, 32'd4);  wait_ticks(3); chk("R4 N=4 gap", 32'(last_gap), 32'(FIX * 5));
        wr(2'd1, 32'hFFFF_FFE2); wait_ticks(3); chk("R4 N=2 field gap", 32'(last_gap), 32'(FIX * 3));
    endtask

    task automatic t_reload;
        wr(2'd1, 32'd1); wait_ticks(3);
        chk("R5 base gap", 32'(last_gap), 32'(FIX * 2));
        wait_ticks(1);
        wr(2'd1, 32'd3);
        wait_ticks(1); chk("R5 old N kept", 32'(last_gap), 32'(FIX * 2));
        wait_ticks(1); chk("R5 new N used", 32'(last_gap), 32'(FIX * 4));
    endtask

    task automatic t_key;
        logic [31:0] d;
        ext_osc_ok = 1'b1;
        wr(2'd0, 32'h1234_8011);
        rd(2'd0, d); chk("R2 bad key ignored", d, 32'h0);
        wr(2'd0, 32'h16AA_FFFF);
        rd(2'd0, d); chk("R3 read layout", d, 32'h0000_8011);
        wr(2'd0, 32'h16AB_0000);
        rd(2'd0, d); chk("R2 near key ignored", d, 32'h0000_8011);
        wr(2'd0, 32'h16AA_0000);
        rd(2'd0, d); chk("R2 key clears", d, 32'h0);
    endtask

    task automatic t_ext;
        int c;
        wr(2'd0, 32'h16AA_0011);
        idle(2);
        c = tick_cnt;
        idle(200);
        chk("R6 internal ignored", 32'(tick_cnt - c), 32'h0);
        @(negedge clk); ext_osc_tick = 1'b1;
        @(negedge clk); ext_osc_tick = 1'b0;
        chk("R6 ext beat", {31'd0, slow_tick}, 32'h1);
        @(negedge clk);
        chk("R6 single cycle", {31'd0, slow_tick}, 32'h0);
    endtask

    task automatic t_noen;
        int c;
        wr(2'd0, 32'h16AA_0001);
        idle(2);
        c = tick_cnt;
        @(negedge clk); ext_osc_tick = 1'b1;
        @(negedge clk); ext_osc_tick = 1'b0;
        idle(150);
        chk("R7 silent", 32'(tick_cnt - c), 32'h0);
    endtask

    task automatic t_bypass;
        logic [31:0] d;
        wr(2'd0, 32'h16AA_8011);
        ext_osc_ok = 1'b0;
        idle(5);
        rd(2'd0, d); chk("R9 select held", d, 32'h0000_8011);
    endtask

    task automatic t_fallback;
        logic [31:0] d;
        ext_osc_ok = 1'b1;
        wr(2'd0, 32'h16AA_0011);
        rd(2'd0, d); chk("R8 ext selected", d, 32'h0000_0011);
        ext_osc_ok = 1'b0;
        idle(3);
        rd(2'd0, d); chk("R8 reverted", d, 32'h0000_0010);
        wr(2'd1, 32'd0);
        wait_ticks(3); chk("R8 internal resumes", 32'(last_gap), 32'(FIX));
    endtask

    task automatic t_gate;
        int c, o;
        logic [31:0] d;
        chk("R10 gate off silent", 32'(out_cnt), 32'h0);
        wr(2'd2, 32'h1);
        rd(2'd2, d); chk("R10 gate reads", d, 32'h1);
        wait_ticks(1);
        c = tick_cnt; o = out_cnt;
        wait_ticks(3);
        chk("R10 copy count", 32'(out_cnt - o), 32'(tick_cnt - c));
        wr(2'd2, 32'h0);
        o = out_cnt;
        wait_ticks(2);
        chk("R10 gate off again", 32'(out_cnt - o), 32'h0);
    endtask

    initial begin
        #(20 * 150000);
        bad = bad + 1; total = total + 1;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset;
        t_period;
        t_reload;
        t_key;
        t_ext;
        t_noen;
        t_bypass;
        t_fallback;
        t_gate;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule